// File: doc/BRIEF.md
# Multi-chain scan test sequencer

This block runs a complete scan test on a small circuit under test that lives inside it. The circuit is a bank of mux-D scan flip-flops wrapped around a fixed combinational function. The flip-flops are split into several equal-length chains. An idle-time write port loads the stimulus words and the expected-response words into an internal store. A single start pulse then runs the whole test with no further input.

For every vector the sequencer shifts the stimulus into all chains in parallel. It then drops scan mode for one capture cycle, so the function's output is clocked into the flip-flops. The captured response is shifted out while the next stimulus is shifted in. After the last capture, a final unload phase empties the chains.

Every bit that leaves a chain is compared with the stored expected word. Any difference sets a sticky fail flag. A cycle counter records how long the run took, and a done flag marks the end of the run.

Top module: `scan_test_seq`

## Requirements
- R1: After reset, busy, done, fail, scan_mode and cycle_cnt are 0, and every scan flip-flop holds 0.
- R2: Each scan cell takes the cell upstream of it (or the chain input) while scan_mode is 1, and the circuit's function output while scan_mode is 0. Cells change only while busy.
- R3: There are NUM_CHAINS chains of CHAIN_LEN cells. Chain c, position p holds circuit bit c*CHAIN_LEN+p. Data shifts from position CHAIN_LEN-1 toward position 0, and scan_out[c] is position 0. So shift cycle j of a vector loads stimulus bit c*CHAIN_LEN+j and presents response bit c*CHAIN_LEN+j.
- R4: The circuit function is out[i] = x[i-1] XOR (x[i] AND x[i+1]), with indices taken modulo NUM_CHAINS*CHAIN_LEN.
- R5: While busy, scan_mode is 1 for CHAIN_LEN shift cycles and 0 for exactly one capture cycle, once per vector. It is then 1 for CHAIN_LEN unload cycles. Never more than CHAIN_LEN shift cycles come in a row.
- R6: At done, cycle_cnt equals NUM_VEC*(CHAIN_LEN+1)+CHAIN_LEN.
- R7: Output bits are compared starting with the shift phase of the second vector (against the expected word of the previous vector) and through the final unload (against the last expected word). A mismatch sets fail on the next clock edge.
- R8: fail stays set until the next accepted start. An accepted start clears fail, done and cycle_cnt.
- R9: done goes to 1 on the cycle after the last unload bit, with busy 0, and holds until the next accepted start.
- R10: A start pulse while busy is ignored. The run's length, result and done timing are unchanged.
- R11: Store writes made while idle take effect for the next run. Writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single test clock for all scan cells |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| wr_en | input | 1 | Write one store entry |
| wr_idx | input | IDX_W | Vector index to write |
| wr_stim | input | NUM_CHAINS*CHAIN_LEN | Stimulus word |
| wr_exp | input | NUM_CHAINS*CHAIN_LEN | Expected response word |
| scan_mode | output | 1 | 1 = shift, 0 = functional capture or idle |
| scan_out | output | NUM_CHAINS | Serial output of each chain |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Sticky mismatch flag |
| cycle_cnt | output | CNT_W | Busy cycles counted since the last start |

## Verification
Number the busy cycles from 0, starting with the first edge after start is sampled. Cycle i belongs to vector i/(CHAIN_LEN+1), and i mod (CHAIN_LEN+1) equal to CHAIN_LEN is the capture cycle. The bench predicts scan_mode and scan_out for each cycle from this numbering and checks them half a period after the edge.

A mismatch in cycle k shows on fail at cycle k+1. The bench places corrupted bits so that the flag must stay 0 up to that cycle and be 1 from then on. One corrupted bit sits on the very last unload bit, so the flag first appears together with done.

done and the final count are due one cycle after busy cycle NUM_VEC*(CHAIN_LEN+1)+CHAIN_LEN-1. A scoreboard queue holds the predicted count and verdict, and a monitor pops it when done rises.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SHIFT   = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_UNLOAD  = 2'd3
  } seq_state_e;

  // busy cycles of a full run with overlapped load/unload
  function automatic int unsigned run_cycles(input int unsigned nvec, input int unsigned len);
    return nvec * (len + 1) + len;
  endfunction

  // index width with a floor of one bit
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int LEN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           scan_mode,
  input  logic           si,
  input  logic [LEN-1:0] func_d,
  output logic [LEN-1:0] q,
  output logic           so
);

  logic [LEN-1:0] nxt;

  for (genvar p = 0; p < LEN; p++) begin : g_cell
    if (p == LEN - 1) begin : g_head
      assign nxt[p] = scan_mode ? si : func_d[p];
    end else begin : g_body
      assign nxt[p] = scan_mode ? q[p+1] : func_d[p];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)  q[p] <= 1'b0;
      else if (en) q[p] <= nxt[p];
    end
  end

  assign so = q[0];

endmodule

// File: rtl/cut_logic.sv
module cut_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);

  function automatic logic [W-1:0] next_state(input logic [W-1:0] v);
    logic [W-1:0] rot_up, rot_dn;
    rot_up = {v[W-2:0], v[W-1]};   // bit i <- v[i-1]
    rot_dn = {v[0], v[W-1:1]};     // bit i <- v[i+1]
    return rot_up ^ (v & rot_dn);
  endfunction

  assign y = next_state(x);

endmodule

// File: rtl/vec_store.sv
module vec_store #(
  parameter int W  = 16,
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_stim,
  input  logic [W-1:0]  wr_exp,
  input  logic [IW-1:0] stim_idx,
  input  logic [IW-1:0] exp_idx,
  output logic [W-1:0]  stim_word,
  output logic [W-1:0]  exp_word
);

  logic [W-1:0] stim_q [N];
  logic [W-1:0] exp_q  [N];

  for (genvar k = 0; k < N; k++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stim_q[k] <= '0;
        exp_q[k]  <= '0;
      end else if (wr_en && !lock && (wr_idx == IW'(k))) begin
        stim_q[k] <= wr_stim;
        exp_q[k]  <= wr_exp;
      end
    end
  end

  assign stim_word = stim_q[stim_idx];
  assign exp_word  = exp_q[exp_idx];

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int LEN   = 4,
  parameter int NVEC  = 6,
  parameter int IW    = 3,
  parameter int BW    = 2,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mismatch,
  output logic             start_acc,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             scan_mode,
  output logic             cmp_en,
  output logic [IW-1:0]    vec_idx,
  output logic [IW-1:0]    cmp_idx,
  output logic [BW-1:0]    bit_idx,
  output logic             unloading,
  output logic [CNT_W-1:0] cycle_cnt
);

  localparam logic [BW-1:0] LAST_BIT = BW'(LEN - 1);
  localparam logic [IW-1:0] LAST_VEC = IW'(NVEC - 1);

  seq_state_e state;
  logic       have_resp;

  assign busy      = (state != ST_IDLE);
  assign start_acc = start && !busy;
  assign scan_mode = (state == ST_SHIFT) || (state == ST_UNLOAD);
  assign unloading = (state == ST_UNLOAD);
  assign cmp_en    = ((state == ST_SHIFT) && have_resp) || unloading;
  assign cmp_idx   = unloading ? LAST_VEC : (vec_idx - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      vec_idx   <= '0;
      bit_idx   <= '0;
      have_resp <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      cycle_cnt <= '0;
    end else if (start_acc) begin
      state     <= ST_SHIFT;
      vec_idx   <= '0;
      bit_idx   <= '0;
      have_resp <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      cycle_cnt <= '0;
    end else if (busy) begin
      cycle_cnt <= cycle_cnt + 1'b1;
      if (mismatch) fail <= 1'b1;
      unique case (state)
        ST_SHIFT: begin
          if (bit_idx == LAST_BIT) begin
            bit_idx <= '0;
            state   <= ST_CAPTURE;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_CAPTURE: begin
          have_resp <= 1'b1;
          if (vec_idx == LAST_VEC) begin
            state <= ST_UNLOAD;
          end else begin
            vec_idx <= vec_idx + 1'b1;
            state   <= ST_SHIFT;
          end
        end
        ST_UNLOAD: begin
          if (bit_idx == LAST_BIT) begin
            bit_idx <= '0;
            state   <= ST_IDLE;
            done    <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int NUM_CHAINS = 4,
  parameter int CHAIN_LEN  = 4,
  parameter int NUM_VEC    = 6,
  parameter int IDX_W      = idx_bits(NUM_VEC),
  parameter int CNT_W      = $clog2(run_cycles(NUM_VEC, CHAIN_LEN) + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [NUM_CHAINS*CHAIN_LEN-1:0] wr_stim,
  input  logic [NUM_CHAINS*CHAIN_LEN-1:0] wr_exp,
  output logic                            scan_mode,
  output logic [NUM_CHAINS-1:0]           scan_out,
  output logic                            busy,
  output logic                            done,
  output logic                            fail,
  output logic [CNT_W-1:0]                cycle_cnt
);

  localparam int FF_N = NUM_CHAINS * CHAIN_LEN;
  localparam int BW   = idx_bits(CHAIN_LEN);

  // events brought out for the checker
  logic                   start_acc;
  logic                   mismatch;
  logic                   cmp_en;
  logic                   unloading;
  logic [IDX_W-1:0]       vec_idx;
  logic [IDX_W-1:0]       cmp_idx;
  logic [BW-1:0]          bit_idx;

  logic [FF_N-1:0]        stim_word;
  logic [FF_N-1:0]        exp_word;
  logic [FF_N-1:0]        cut_q;
  logic [FF_N-1:0]        cut_d;
  logic [NUM_CHAINS-1:0]  chain_si;
  logic [NUM_CHAINS-1:0]  exp_bit;

  logic [NUM_CHAINS-1:0][CHAIN_LEN-1:0] chain_q;
  logic [NUM_CHAINS-1:0][CHAIN_LEN-1:0] func_arr;
  logic [NUM_CHAINS-1:0][CHAIN_LEN-1:0] stim_arr;
  logic [NUM_CHAINS-1:0][CHAIN_LEN-1:0] exp_arr;

  seq_ctrl #(
    .LEN  (CHAIN_LEN),
    .NVEC (NUM_VEC),
    .IW   (IDX_W),
    .BW   (BW),
    .CNT_W(CNT_W)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mismatch (mismatch),
    .start_acc(start_acc),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .scan_mode(scan_mode),
    .cmp_en   (cmp_en),
    .vec_idx  (vec_idx),
    .cmp_idx  (cmp_idx),
    .bit_idx  (bit_idx),
    .unloading(unloading),
    .cycle_cnt(cycle_cnt)
  );

  vec_store #(
    .W (FF_N),
    .N (NUM_VEC),
    .IW(IDX_W)
  ) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock     (busy),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_stim  (wr_stim),
    .wr_exp   (wr_exp),
    .stim_idx (vec_idx),
    .exp_idx  (cmp_idx),
    .stim_word(stim_word),
    .exp_word (exp_word)
  );

  cut_logic #(.W(FF_N)) i_cut (
    .x(cut_q),
    .y(cut_d)
  );

  assign cut_q    = chain_q;
  assign func_arr = cut_d;
  assign stim_arr = stim_word;
  assign exp_arr  = exp_word;

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    assign chain_si[c] = unloading ? 1'b0 : stim_arr[c][bit_idx];
    assign exp_bit[c]  = exp_arr[c][bit_idx];

    scan_chain #(.LEN(CHAIN_LEN)) i_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (busy),
      .scan_mode(scan_mode),
      .si       (chain_si[c]),
      .func_d   (func_arr[c]),
      .q        (chain_q[c]),
      .so       (scan_out[c])
    );
  end

  assign mismatch = cmp_en && (scan_out != exp_bit);

endmodule

// File: rtl/scan_test_seq_chk.sv
module scan_test_seq_chk #(
  parameter int CHAIN_LEN = 4,
  parameter int TOTAL     = 34,
  parameter int CNT_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             start_acc,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic             scan_mode,
  input logic             mismatch,
  input logic [CNT_W-1:0] cycle_cnt
);

  localparam int RW = $clog2(CHAIN_LEN + 2) + 1;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)                run_len <= '0;
    else if (busy && scan_mode) run_len <= run_len + 1'b1;
    else                       run_len <= '0;
  end

  AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_mode) |=> scan_mode);  // R5
  AST_SHIFT_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RW'(CHAIN_LEN));  // R5
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cycle_cnt == CNT_W'(TOTAL)));  // R6
  AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> fail);  // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start_acc) |=> fail);  // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (busy && !fail && !done && (cycle_cnt == '0)));  // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cycle_cnt != '0));  // R10

endmodule

bind scan_test_seq scan_test_seq_chk #(
  .CHAIN_LEN(CHAIN_LEN),
  .TOTAL    (scan_seq_pkg::run_cycles(NUM_VEC, CHAIN_LEN)),
  .CNT_W    (CNT_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .start_acc(start_acc),
  .busy     (busy),
  .done     (done),
  .fail     (fail),
  .scan_mode(scan_mode),
  .mismatch (mismatch),
  .cycle_cnt(cycle_cnt)
);

// File: tb/test_scan_test_seq.sv
module test_scan_test_seq;

  localparam int M     = 4;
  localparam int L     = 4;
  localparam int V     = 6;
  localparam int F     = M * L;
  localparam int IW    = 3;
  localparam int CW    = 6;
  localparam int TOTAL = V * L + V + L;   // V*(L+1)+L

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [F-1:0]  wr_stim = '0;
  logic [F-1:0]  wr_exp = '0;
  logic          scan_mode;
  logic [M-1:0]  scan_out;
  logic          busy;
  logic          done;
  logic          fail;
  logic [CW-1:0] cycle_cnt;

  int checks = 0;
  int failures = 0;

  logic [F-1:0] stim_m [V];
  logic [F-1:0] exp_m  [V];

  typedef struct { int cnt; bit fail; } result_t;
  result_t sb_q[$];

  always #2.5 clk = ~clk;

  scan_test_seq #(.NUM_CHAINS(M), .CHAIN_LEN(L), .NUM_VEC(V)) i_scan_test_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_stim(wr_stim), .wr_exp(wr_exp), .scan_mode(scan_mode), .scan_out(scan_out),
    .busy(busy), .done(done), .fail(fail), .cycle_cnt(cycle_cnt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // R4: bitwise restatement of the circuit function
  function automatic logic [F-1:0] model_cut(input logic [F-1:0] x);
    logic [F-1:0] r;
    for (int i = 0; i < F; i++)
      r[i] = x[(i + F - 1) % F] ^ (x[i] & x[(i + 1) % F]);
    return r;
  endfunction

  task automatic write_vec(input int idx, input logic [F-1:0] s, input logic [F-1:0] e);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_stim = s; wr_exp = e;
    @(negedge clk);
    wr_en = 1'b0;
    stim_m[idx] = s;
    exp_m[idx]  = e;
  endtask

  task automatic load_pattern(input int kind);
    for (int k = 0; k < V; k++) begin
      logic [F-1:0] s;
      if (kind == 0) s = F'(16'hA5C3 ^ (k * 16'h1357));
      else           s = (k % 2 == 0) ? '1 : '0;
      write_vec(k, s, model_cut(s));
    end
  endtask

  // driver: pushes the predicted outcome, then walks every busy cycle
  task automatic run_seq(input int fail_at, input int restart_at, input int wr_at);
    result_t r;
    r.cnt = TOTAL; r.fail = (fail_at >= 0);
    sb_q.push_back(r);
    @(negedge clk);
    start = 1'b1;
    for (int i = 0; i < TOTAL; i++) begin
      int blk, pos, src;
      logic [F-1:0] resp;
      logic [M-1:0] so_exp;
      bit known;
      @(negedge clk);
      blk = i / (L + 1);
      pos = i % (L + 1);
      chk(busy == 1'b1, "R9 busy during run", busy, 1);
      chk(fail == ((fail_at >= 0) && (i > fail_at)), "R7/R8 fail timing", fail,
          (fail_at >= 0) && (i > fail_at));
      if (blk >= V) begin
        chk(scan_mode == 1'b1, "R5 unload scan_mode", scan_mode, 1);
        src = V - 1; known = 1;
      end else if (pos == L) begin
        chk(scan_mode == 1'b0, "R5 capture scan_mode", scan_mode, 0);
        src = 0; known = 0;
      end else begin
        chk(scan_mode == 1'b1, "R5 shift scan_mode", scan_mode, 1);
        src = blk - 1; known = (blk >= 1);
      end
      if (known) begin
        resp = model_cut(stim_m[src]);
        for (int c = 0; c < M; c++) so_exp[c] = resp[c * L + pos];
        chk(scan_out == so_exp, "R2/R3/R4 scan_out response bits", scan_out, so_exp);
      end
      start = (i == restart_at);           // R10: ignored while busy
      if (i == wr_at) begin                // R11: ignored while busy
        wr_en = 1'b1; wr_idx = IW'(V - 1);
        wr_stim = stim_m[V-1]; wr_exp = ~exp_m[V-1];
      end else begin
        wr_en = 1'b0;
      end
    end
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    chk(done == 1'b1, "R9 done after last unload bit", done, 1);
    chk(busy == 1'b0, "R9 idle at done", busy, 0);
    chk(scan_mode == 1'b0, "R5 scan_mode low when idle", scan_mode, 0);
    @(negedge clk);
  endtask

  // monitor: pops the prediction when done rises
  initial begin
    forever begin
      @(posedge done);
      @(negedge clk);
      if (sb_q.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        result_t r;
        r = sb_q.pop_front();
        chk(cycle_cnt == CW'(r.cnt), "R6 cycle count at done", cycle_cnt, r.cnt);
        chk(fail == r.fail, "R7 verdict at done", fail, r.fail);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done after reset", {busy, done}, 0);
    chk(fail == 1'b0, "R1 fail after reset", fail, 0);
    chk(cycle_cnt == '0, "R1 cycle_cnt after reset", cycle_cnt, 0);
    chk(scan_mode == 1'b0, "R1 scan_mode after reset", scan_mode, 0);
    chk(scan_out == '0, "R1 chains cleared", scan_out, 0);

    // mixed pattern, clean run
    load_pattern(0);
    run_seq(-1, -1, -1);

    // all-ones / all-zeros pattern, clean run
    load_pattern(1);
    run_seq(-1, -1, -1);

    // R11: idle write corrupts expected word 0 bit 5 (chain 1, position 1),
    // first compared at busy cycle L+1+1
    write_vec(0, stim_m[0], exp_m[0] ^ (F'(1) << 5));
    run_seq(L + 2, -1, -1);
    repeat (3) @(negedge clk);
    chk(fail == 1'b1, "R8 fail held while idle", fail, 1);
    chk(done == 1'b1, "R9 done held while idle", done, 1);

    // R8: repaired store, next start clears the flag
    write_vec(0, stim_m[0], model_cut(stim_m[0]));
    run_seq(-1, -1, -1);

    // R7: last unload bit (chain M-1, position L-1) is the only bad one
    write_vec(V - 1, stim_m[V-1], exp_m[V-1] ^ (F'(1) << (F - 1)));
    run_seq(TOTAL - 1, -1, -1);
    write_vec(V - 1, stim_m[V-1], model_cut(stim_m[V-1]));

    // R10: restart pulse mid-run
    load_pattern(0);
    run_seq(-1, 10, -1);

    // R11: write of a bad expected word while busy must not land
    run_seq(-1, -1, 3);
    run_seq(-1, -1, -1);

    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, "R6 all runs reported", sb_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule